// File: doc/BRIEF.md
# Queue Doorbell Register Decoder

This block sits behind the register port of a host-facing storage controller and turns writes into the doorbell window into pointer updates for a fixed set of queue pairs. Each queue index owns two 4-byte slots, one behind the other. The first slot takes a new tail for the submission queue. The second takes a new head for the completion queue. The block stores, for every queue, whether it exists, its size, its pointer, and for submission queues the completion queue they report to.

An accepted submission tail write tells the command fetch engine to look at that queue again. An accepted completion head write may free a completion queue that was full. When it does, every submission queue bound to that completion queue is kicked and the posting engine is told to resume. If entries still remain after the head moves, an interrupt request is raised. Writes that are malformed or that name a missing queue or an out-of-range value are dropped without a trace. Queues are created and deleted over a separate sideband port. The posting engine reports each new completion tail over its own port. A read port returns any stored pointer.

Top module: `dbd_doorbell_top`

## Requirements
- R1: A write whose address is below the window base (0x1000), or whose low two address bits are not zero, changes no pointer and raises no output pulse.
- R2: With offset = address − 0x1000, offset bit 2 clear selects a submission tail doorbell and offset bit 2 set selects a completion head doorbell; the queue index is offset >> 3 for both.
- R3: A write whose queue index is NUM_Q or above, or that names a queue not currently created, is dropped.
- R4: Only data bits [15:0] are used; a value greater than or equal to the queue size is dropped and the stored pointer keeps its value.
- R5: An accepted submission tail write stores the tail and pulses sq_kick at that queue's bit in the cycle after the write.
- R6: An accepted completion head write to a queue that was full before the write (tail+1 modulo size equals head) pulses sq_kick for every created submission queue bound to it and pulses cq_resume at its bit, in the cycle after the write.
- R7: After an accepted completion head write, cq_irq pulses at that queue's bit in the next cycle if the new head differs from the stored tail.
- R8: A sideband create marks the queue present, stores its size (and binding, for submission queues) and sets its pointers to 0; a delete marks it absent so later doorbells to it are dropped.
- R9: rd_ptr returns, one cycle after the request, the submission tail (rd_is_cq = 0) or the completion head (rd_is_cq = 1) of rd_qid.
- R10: Synchronous reset marks every queue absent, zeroes all pointers and holds all outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| db_wr_en | input | 1 | Register write strobe |
| db_wr_addr | input | ADDR_W | Byte address of the write |
| db_wr_data | input | DATA_W | Write data; low PTR_W bits used |
| q_cfg_en | input | 1 | Sideband queue create/delete strobe |
| q_cfg_is_cq | input | 1 | 1 = completion queue, 0 = submission queue |
| q_cfg_create | input | 1 | 1 = create, 0 = delete |
| q_cfg_qid | input | QID_W | Queue index being created or deleted |
| q_cfg_size | input | PTR_W | Number of entries of the new queue |
| q_cfg_cq_bind | input | QID_W | Completion queue a new submission queue reports to |
| cq_tail_en | input | 1 | Posting engine reports a new completion tail |
| cq_tail_qid | input | QID_W | Completion queue of the report |
| cq_tail_val | input | PTR_W | New completion tail (dropped unless below size) |
| rd_is_cq | input | 1 | Read selects completion head (1) or submission tail (0) |
| rd_qid | input | QID_W | Queue index to read |
| rd_ptr | output | PTR_W | Pointer read result, one cycle later |
| sq_kick | output | NUM_Q | One-cycle fetch request per submission queue |
| cq_resume | output | NUM_Q | One-cycle posting resume per completion queue |
| cq_irq | output | NUM_Q | One-cycle interrupt request per completion queue |

## Verification
Every result of this block is due exactly one clock after the write, report or read that causes it: the kick, resume and interrupt pulses and the read data are all registered once, and a pointer stored at an edge is visible on rd_ptr one cycle after a read issued in the following cycle. The bench drives inputs on the falling edge, advances a behavioural model of the queue state on the rising edge using the same inputs, and compares the three pulse vectors and the read data on the next falling edge, every cycle. Directed sequences capture the outputs one cycle after each stimulus to check the full-queue restart, the interrupt condition and each dropped-write case.

// File: rtl/dbd_pkg.sv
package dbd_pkg;

  // Kind of doorbell slot selected by offset bit 2
  typedef enum logic {
    DB_SQ_TAIL = 1'b0,
    DB_CQ_HEAD = 1'b1
  } db_kind_e;

  // Each queue index owns two 4-byte slots, so 8 bytes per index
  localparam int DB_KIND_BIT   = 2;
  localparam int DB_INDEX_SHIFT = 3;

endpackage

// File: rtl/dbd_addr_decode.sv
module dbd_addr_decode
  import dbd_pkg::*;
#(
  parameter int          NUM_Q   = 64,
  parameter int          ADDR_W  = 16,
  parameter int unsigned DB_BASE = 32'h1000,
  localparam int         QID_W   = $clog2(NUM_Q)
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              slot_hit,
  output db_kind_e          slot_kind,
  output logic [QID_W-1:0]  slot_qid
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(DB_BASE);
  localparam logic [ADDR_W-1:0] QCOUNT = ADDR_W'(NUM_Q);

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] slot_idx;
  logic              in_window;
  logic              aligned;
  logic              in_range;

  always_comb begin
    offset    = wr_addr - BASE_A;
    in_window = (wr_addr >= BASE_A);
    aligned   = (offset[1:0] == 2'b00);
    slot_idx  = offset >> DB_INDEX_SHIFT;
    in_range  = (slot_idx < QCOUNT);
    slot_hit  = wr_en && in_window && aligned && in_range;
    slot_kind = db_kind_e'(offset[DB_KIND_BIT]);
    slot_qid  = slot_idx[QID_W-1:0];
  end

endmodule

// File: rtl/dbd_sq_table.sv
module dbd_sq_table #(
  parameter int  NUM_Q = 64,
  parameter int  PTR_W = 16,
  localparam int QID_W = $clog2(NUM_Q)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_en,
  input  logic                             cfg_create,
  input  logic [QID_W-1:0]                 cfg_qid,
  input  logic [PTR_W-1:0]                 cfg_size,
  input  logic [QID_W-1:0]                 cfg_bind,
  input  logic                             tail_wr,
  input  logic [QID_W-1:0]                 tail_qid,
  input  logic [PTR_W-1:0]                 tail_val,
  output logic [NUM_Q-1:0]                 sq_valid,
  output logic [NUM_Q-1:0][PTR_W-1:0]      sq_size,
  output logic [NUM_Q-1:0][QID_W-1:0]      sq_bind,
  output logic [NUM_Q-1:0][PTR_W-1:0]      sq_tail
);

  for (genvar q = 0; q < NUM_Q; q++) begin : g_sq
    always_ff @(posedge clk) begin
      if (rst) begin
        sq_valid[q] <= 1'b0;
        sq_size[q]  <= '0;
        sq_bind[q]  <= '0;
        sq_tail[q]  <= '0;
      end else if (cfg_en && cfg_qid == QID_W'(q)) begin
        sq_valid[q] <= cfg_create;
        if (cfg_create) begin
          sq_size[q] <= cfg_size;
          sq_bind[q] <= cfg_bind;
          sq_tail[q] <= '0;
        end
      end else if (tail_wr && tail_qid == QID_W'(q)) begin
        sq_tail[q] <= tail_val;
      end
    end
  end

endmodule

// File: rtl/dbd_cq_table.sv
module dbd_cq_table #(
  parameter int  NUM_Q = 64,
  parameter int  PTR_W = 16,
  localparam int QID_W = $clog2(NUM_Q)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_en,
  input  logic                             cfg_create,
  input  logic [QID_W-1:0]                 cfg_qid,
  input  logic [PTR_W-1:0]                 cfg_size,
  input  logic                             head_wr,
  input  logic [QID_W-1:0]                 head_qid,
  input  logic [PTR_W-1:0]                 head_val,
  input  logic                             tail_wr,
  input  logic [QID_W-1:0]                 tail_qid,
  input  logic [PTR_W-1:0]                 tail_val,
  output logic [NUM_Q-1:0]                 cq_valid,
  output logic [NUM_Q-1:0][PTR_W-1:0]      cq_size,
  output logic [NUM_Q-1:0][PTR_W-1:0]      cq_head,
  output logic [NUM_Q-1:0][PTR_W-1:0]      cq_tail
);

  for (genvar q = 0; q < NUM_Q; q++) begin : g_cq
    always_ff @(posedge clk) begin
      if (rst) begin
        cq_valid[q] <= 1'b0;
        cq_size[q]  <= '0;
        cq_head[q]  <= '0;
        cq_tail[q]  <= '0;
      end else if (cfg_en && cfg_qid == QID_W'(q)) begin
        cq_valid[q] <= cfg_create;
        if (cfg_create) begin
          cq_size[q] <= cfg_size;
          cq_head[q] <= '0;
          cq_tail[q] <= '0;
        end
      end else begin
        if (head_wr && head_qid == QID_W'(q)) cq_head[q] <= head_val;
        if (tail_wr && tail_qid == QID_W'(q)) cq_tail[q] <= tail_val;
      end
    end
  end

endmodule

// File: rtl/dbd_doorbell_top.sv
module dbd_doorbell_top
  import dbd_pkg::*;
#(
  parameter int          NUM_Q   = 64,
  parameter int          ADDR_W  = 16,
  parameter int          DATA_W  = 32,
  parameter int          PTR_W   = 16,
  parameter int unsigned DB_BASE = 32'h1000,
  localparam int         QID_W   = $clog2(NUM_Q)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              db_wr_en,
  input  logic [ADDR_W-1:0] db_wr_addr,
  input  logic [DATA_W-1:0] db_wr_data,
  input  logic              q_cfg_en,
  input  logic              q_cfg_is_cq,
  input  logic              q_cfg_create,
  input  logic [QID_W-1:0]  q_cfg_qid,
  input  logic [PTR_W-1:0]  q_cfg_size,
  input  logic [QID_W-1:0]  q_cfg_cq_bind,
  input  logic              cq_tail_en,
  input  logic [QID_W-1:0]  cq_tail_qid,
  input  logic [PTR_W-1:0]  cq_tail_val,
  input  logic              rd_is_cq,
  input  logic [QID_W-1:0]  rd_qid,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic [NUM_Q-1:0]  sq_kick,
  output logic [NUM_Q-1:0]  cq_resume,
  output logic [NUM_Q-1:0]  cq_irq
);

  localparam logic [NUM_Q-1:0] ONE_BIT = NUM_Q'(1);

  logic             slot_hit;
  db_kind_e         slot_kind;
  logic [QID_W-1:0] slot_qid;
  logic [PTR_W-1:0] new_ptr;
  logic             unused_data;

  logic [NUM_Q-1:0]            sq_valid;
  logic [NUM_Q-1:0][PTR_W-1:0] sq_size;
  logic [NUM_Q-1:0][QID_W-1:0] sq_bind;
  logic [NUM_Q-1:0][PTR_W-1:0] sq_tail;
  logic [NUM_Q-1:0]            cq_valid;
  logic [NUM_Q-1:0][PTR_W-1:0] cq_size;
  logic [NUM_Q-1:0][PTR_W-1:0] cq_head;
  logic [NUM_Q-1:0][PTR_W-1:0] cq_tail;

  logic             sq_accept;
  logic             cq_accept;
  logic             tail_accept;
  logic [PTR_W-1:0] tail_plus;
  logic [PTR_W-1:0] tail_wrapped;
  logic             cq_was_full;
  logic [NUM_Q-1:0] bound_sqs;
  logic [NUM_Q-1:0] slot_1h;

  assign new_ptr     = db_wr_data[PTR_W-1:0];
  assign unused_data = ^db_wr_data;

  dbd_addr_decode #(
    .NUM_Q  (NUM_Q),
    .ADDR_W (ADDR_W),
    .DB_BASE(DB_BASE)
  ) u_decode (
    .wr_en    (db_wr_en),
    .wr_addr  (db_wr_addr),
    .slot_hit (slot_hit),
    .slot_kind(slot_kind),
    .slot_qid (slot_qid)
  );

  // Acceptance: slot decoded, queue present, value inside the ring
  always_comb begin
    slot_1h      = ONE_BIT << slot_qid;
    sq_accept    = slot_hit && (slot_kind == DB_SQ_TAIL) && sq_valid[slot_qid]
                   && (new_ptr < sq_size[slot_qid]);
    cq_accept    = slot_hit && (slot_kind == DB_CQ_HEAD) && cq_valid[slot_qid]
                   && (new_ptr < cq_size[slot_qid]);
    tail_accept  = cq_tail_en && cq_valid[cq_tail_qid]
                   && (cq_tail_val < cq_size[cq_tail_qid]);
    tail_plus    = cq_tail[slot_qid] + PTR_W'(1);
    tail_wrapped = (tail_plus == cq_size[slot_qid]) ? '0 : tail_plus;
    cq_was_full  = (tail_wrapped == cq_head[slot_qid]);
  end

  // Submission queues reporting to the addressed completion queue
  for (genvar s = 0; s < NUM_Q; s++) begin : g_bound
    assign bound_sqs[s] = sq_valid[s] && (sq_bind[s] == slot_qid);
  end

  dbd_sq_table #(
    .NUM_Q(NUM_Q),
    .PTR_W(PTR_W)
  ) u_sq_table (
    .clk       (clk),
    .rst       (rst),
    .cfg_en    (q_cfg_en && !q_cfg_is_cq),
    .cfg_create(q_cfg_create),
    .cfg_qid   (q_cfg_qid),
    .cfg_size  (q_cfg_size),
    .cfg_bind  (q_cfg_cq_bind),
    .tail_wr   (sq_accept),
    .tail_qid  (slot_qid),
    .tail_val  (new_ptr),
    .sq_valid  (sq_valid),
    .sq_size   (sq_size),
    .sq_bind   (sq_bind),
    .sq_tail   (sq_tail)
  );

  dbd_cq_table #(
    .NUM_Q(NUM_Q),
    .PTR_W(PTR_W)
  ) u_cq_table (
    .clk       (clk),
    .rst       (rst),
    .cfg_en    (q_cfg_en && q_cfg_is_cq),
    .cfg_create(q_cfg_create),
    .cfg_qid   (q_cfg_qid),
    .cfg_size  (q_cfg_size),
    .head_wr   (cq_accept),
    .head_qid  (slot_qid),
    .head_val  (new_ptr),
    .tail_wr   (tail_accept),
    .tail_qid  (cq_tail_qid),
    .tail_val  (cq_tail_val),
    .cq_valid  (cq_valid),
    .cq_size   (cq_size),
    .cq_head   (cq_head),
    .cq_tail   (cq_tail)
  );

  // Registered pulses and read data
  always_ff @(posedge clk) begin
    if (rst) begin
      sq_kick   <= '0;
      cq_resume <= '0;
      cq_irq    <= '0;
      rd_ptr    <= '0;
    end else begin
      sq_kick   <= (sq_accept ? slot_1h : '0)
                 | ((cq_accept && cq_was_full) ? bound_sqs : '0);
      cq_resume <= (cq_accept && cq_was_full) ? slot_1h : '0;
      cq_irq    <= (cq_accept && (new_ptr != cq_tail[slot_qid])) ? slot_1h : '0;
      rd_ptr    <= rd_is_cq ? cq_head[rd_qid] : sq_tail[rd_qid];
    end
  end

endmodule

// File: rtl/dbd_checker.sv
module dbd_checker #(
  parameter int          NUM_Q   = 64,
  parameter int          ADDR_W  = 16,
  parameter int unsigned DB_BASE = 32'h1000
) (
  input logic              clk,
  input logic              rst,
  input logic              db_wr_en,
  input logic [ADDR_W-1:0] db_wr_addr,
  input logic [NUM_Q-1:0]  sq_kick,
  input logic [NUM_Q-1:0]  cq_resume,
  input logic [NUM_Q-1:0]  cq_irq
);

  localparam int unsigned WIN_END = DB_BASE + 8 * NUM_Q;

  logic quiet;
  assign quiet = (sq_kick == '0) && (cq_resume == '0) && (cq_irq == '0);

  // R10
  reset_quiet_chk: assert property (@(posedge clk) rst |=> quiet);

  // R1
  unaligned_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (db_wr_en && db_wr_addr[1:0] != 2'b00) |=> quiet);

  // R1
  below_base_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (db_wr_en && 32'(db_wr_addr) < DB_BASE) |=> quiet);

  // R3
  past_window_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (db_wr_en && 32'(db_wr_addr) >= WIN_END) |=> quiet);

  // R5
  kick_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (sq_kick != '0) |-> $past(db_wr_en));

  // R2
  irq_from_head_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (cq_irq != '0) |-> ($past(db_wr_en) && $past(db_wr_addr[2])));

  // R6
  resume_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cq_resume));

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cq_irq));

endmodule

bind dbd_doorbell_top dbd_checker #(
  .NUM_Q  (NUM_Q),
  .ADDR_W (ADDR_W),
  .DB_BASE(DB_BASE)
) u_dbd_checker (
  .clk       (clk),
  .rst       (rst),
  .db_wr_en  (db_wr_en),
  .db_wr_addr(db_wr_addr),
  .sq_kick   (sq_kick),
  .cq_resume (cq_resume),
  .cq_irq    (cq_irq)
);

// File: tb/test_dbd_doorbell_top.sv
module test_dbd_doorbell_top;

  localparam int CLK_PERIOD = 10;
  localparam int NQ    = 64;
  localparam int QW    = $clog2(NQ);
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int PW    = 16;
  localparam int BASE  = 32'h1000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          db_wr_en = 1'b0;
  logic [AW-1:0] db_wr_addr = '0;
  logic [DW-1:0] db_wr_data = '0;
  logic          q_cfg_en = 1'b0, q_cfg_is_cq = 1'b0, q_cfg_create = 1'b0;
  logic [QW-1:0] q_cfg_qid = '0, q_cfg_cq_bind = '0;
  logic [PW-1:0] q_cfg_size = '0;
  logic          cq_tail_en = 1'b0;
  logic [QW-1:0] cq_tail_qid = '0;
  logic [PW-1:0] cq_tail_val = '0;
  logic          rd_is_cq = 1'b0;
  logic [QW-1:0] rd_qid = '0;
  logic [PW-1:0] rd_ptr;
  logic [NQ-1:0] sq_kick, cq_resume, cq_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit live     = 1'b0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbd_doorbell_top i_dbd_doorbell_top (
    .clk(clk), .rst(rst),
    .db_wr_en(db_wr_en), .db_wr_addr(db_wr_addr), .db_wr_data(db_wr_data),
    .q_cfg_en(q_cfg_en), .q_cfg_is_cq(q_cfg_is_cq), .q_cfg_create(q_cfg_create),
    .q_cfg_qid(q_cfg_qid), .q_cfg_size(q_cfg_size), .q_cfg_cq_bind(q_cfg_cq_bind),
    .cq_tail_en(cq_tail_en), .cq_tail_qid(cq_tail_qid), .cq_tail_val(cq_tail_val),
    .rd_is_cq(rd_is_cq), .rd_qid(rd_qid), .rd_ptr(rd_ptr),
    .sq_kick(sq_kick), .cq_resume(cq_resume), .cq_irq(cq_irq)
  );

  // ---------------- behavioural reference model ----------------
  int m_sqv[NQ], m_sqs[NQ], m_sqb[NQ], m_sqt[NQ];
  int m_cqv[NQ], m_cqs[NQ], m_cqh[NQ], m_cqt[NQ];
  logic [NQ-1:0] e_kick, e_res, e_irq;
  int e_rd;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NQ; i++) begin
        m_sqv[i] = 0; m_sqs[i] = 0; m_sqb[i] = 0; m_sqt[i] = 0;
        m_cqv[i] = 0; m_cqs[i] = 0; m_cqh[i] = 0; m_cqt[i] = 0;
      end
      e_kick = '0; e_res = '0; e_irq = '0; e_rd = 0;
      live = 1'b1;
    end else begin
      e_kick = '0; e_res = '0; e_irq = '0;
      e_rd = rd_is_cq ? m_cqh[rd_qid] : m_sqt[rd_qid];
      if (db_wr_en) begin
        int a, v, off, q;
        a = int'(db_wr_addr);
        v = int'(db_wr_data[15:0]);
        if (a >= BASE && (a % 4) == 0) begin
          off = a - BASE;
          q = off / 8;
          if (q < NQ) begin
            if (((off / 4) % 2) == 0) begin
              if (m_sqv[q] != 0 && v < m_sqs[q]) begin
                m_sqt[q] = v;
                e_kick[q] = 1'b1;
              end
            end else if (m_cqv[q] != 0 && v < m_cqs[q]) begin
              if (((m_cqt[q] + 1) % m_cqs[q]) == m_cqh[q]) begin
                for (int s = 0; s < NQ; s++)
                  if (m_sqv[s] != 0 && m_sqb[s] == q) e_kick[s] = 1'b1;
                e_res[q] = 1'b1;
              end
              if (v != m_cqt[q]) e_irq[q] = 1'b1;
              m_cqh[q] = v;
            end
          end
        end
      end
      if (cq_tail_en && m_cqv[cq_tail_qid] != 0 && int'(cq_tail_val) < m_cqs[cq_tail_qid])
        m_cqt[cq_tail_qid] = int'(cq_tail_val);
      if (q_cfg_en) begin
        if (q_cfg_is_cq) begin
          m_cqv[q_cfg_qid] = q_cfg_create;
          if (q_cfg_create) begin
            m_cqs[q_cfg_qid] = int'(q_cfg_size);
            m_cqh[q_cfg_qid] = 0; m_cqt[q_cfg_qid] = 0;
          end
        end else begin
          m_sqv[q_cfg_qid] = q_cfg_create;
          if (q_cfg_create) begin
            m_sqs[q_cfg_qid] = int'(q_cfg_size);
            m_sqb[q_cfg_qid] = int'(q_cfg_cq_bind);
            m_sqt[q_cfg_qid] = 0;
          end
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (live && !done) begin
      n_checks += 4;
      if (sq_kick !== e_kick) begin
        n_fail++;
        $display("FAIL R5 or R6 sq_kick act=%h exp=%h t=%0t", sq_kick, e_kick, $time);
      end
      if (cq_resume !== e_res) begin
        n_fail++;
        $display("FAIL R6 cq_resume act=%h exp=%h t=%0t", cq_resume, e_res, $time);
      end
      if (cq_irq !== e_irq) begin
        n_fail++;
        $display("FAIL R7 cq_irq act=%h exp=%h t=%0t", cq_irq, e_irq, $time);
      end
      if (int'(rd_ptr) != e_rd) begin
        n_fail++;
        $display("FAIL R9 rd_ptr act=%0d exp=%0d t=%0t", rd_ptr, e_rd, $time);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic check_val(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic ring(input int addr, input int data,
                      output logic [NQ-1:0] k, output logic [NQ-1:0] r,
                      output logic [NQ-1:0] i);
    @(negedge clk);
    db_wr_en = 1'b1; db_wr_addr = AW'(addr); db_wr_data = DW'(data);
    @(negedge clk);
    db_wr_en = 1'b0;
    k = sq_kick; r = cq_resume; i = cq_irq;
  endtask

  task automatic cfg(input bit is_cq, input bit create, input int qid,
                     input int size, input int bind_q);
    @(negedge clk);
    q_cfg_en = 1'b1; q_cfg_is_cq = is_cq; q_cfg_create = create;
    q_cfg_qid = QW'(qid); q_cfg_size = PW'(size); q_cfg_cq_bind = QW'(bind_q);
    @(negedge clk);
    q_cfg_en = 1'b0;
  endtask

  task automatic set_tail(input int qid, input int val);
    @(negedge clk);
    cq_tail_en = 1'b1; cq_tail_qid = QW'(qid); cq_tail_val = PW'(val);
    @(negedge clk);
    cq_tail_en = 1'b0;
  endtask

  task automatic read_ptr(input bit is_cq, input int qid, output int val);
    @(negedge clk);
    rd_is_cq = is_cq; rd_qid = QW'(qid);
    @(negedge clk);
    val = int'(rd_ptr);
  endtask

  localparam int SQ_SLOT = 0;
  localparam int CQ_SLOT = 4;

  function automatic int slot(input int q, input int kind);
    return BASE + 8 * q + kind;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [NQ-1:0] k, r, i;
    int v;
    repeat (3) @(negedge clk);
    // R10: outputs quiet in reset
    check_val("R10 kick in reset", longint'(sq_kick), 0);
    check_val("R10 irq in reset", longint'(cq_irq), 0);
    rst = 1'b0;
    read_ptr(1'b0, 0, v);
    check_val("R10 pointer after reset", v, 0);

    // R8: create queues
    cfg(1'b1, 1'b1, 0, 2, 0);
    cfg(1'b0, 1'b1, 0, 2, 0);
    cfg(1'b1, 1'b1, 1, 4, 0);
    cfg(1'b1, 1'b1, 2, 8, 0);
    cfg(1'b0, 1'b1, 1, 4, 1);
    cfg(1'b0, 1'b1, 2, 8, 1);
    cfg(1'b0, 1'b1, 3, 16, 2);

    // R5: accepted tail write
    ring(slot(1, SQ_SLOT), 3, k, r, i);
    check_val("R5 kick on sq1", longint'(k), 64'h2);
    read_ptr(1'b0, 1, v);
    check_val("R5 sq1 tail stored", v, 3);

    // R4: value equal to size dropped
    ring(slot(1, SQ_SLOT), 4, k, r, i);
    check_val("R4 oversize kick", longint'(k), 0);
    read_ptr(1'b0, 1, v);
    check_val("R4 oversize keeps tail", v, 3);

    // R4: upper data bits ignored
    ring(slot(1, SQ_SLOT), 32'hABCD0002, k, r, i);
    check_val("R4 high bits kick", longint'(k), 64'h2);
    read_ptr(1'b0, 1, v);
    check_val("R4 high bits tail", v, 2);

    // R1: unaligned and below base
    ring(BASE + 8 + 2, 1, k, r, i);
    check_val("R1 unaligned kick", longint'(k), 0);
    ring(BASE - 8, 1, k, r, i);
    check_val("R1 below base kick", longint'(k), 0);
    read_ptr(1'b0, 1, v);
    check_val("R1 tail untouched", v, 2);

    // R3: absent queue and index past the last queue
    ring(slot(5, SQ_SLOT), 0, k, r, i);
    check_val("R3 absent queue kick", longint'(k), 0);
    ring(slot(NQ, SQ_SLOT), 0, k, r, i);
    check_val("R3 index out of range kick", longint'(k), 0);

    // R6 and R7: full completion queue 1 (size 4, tail 3, head 0)
    set_tail(1, 3);
    ring(slot(1, CQ_SLOT), 1, k, r, i);
    check_val("R6 restart bound sqs", longint'(k), 64'h6);
    check_val("R6 resume cq1", longint'(r), 64'h2);
    check_val("R7 irq cq1", longint'(i), 64'h2);
    ring(slot(1, CQ_SLOT), 3, k, r, i);
    check_val("R6 not full no kick", longint'(k), 0);
    check_val("R6 not full no resume", longint'(r), 0);
    check_val("R7 head equals tail no irq", longint'(i), 0);

    // R7: cq2 not full
    ring(slot(2, CQ_SLOT), 0, k, r, i);
    check_val("R7 empty no irq", longint'(i), 0);
    set_tail(2, 5);
    ring(slot(2, CQ_SLOT), 2, k, r, i);
    check_val("R7 pending irq cq2", longint'(i), 64'h4);
    check_val("R6 no resume cq2", longint'(r), 0);

    // R4: head >= size dropped
    ring(slot(2, CQ_SLOT), 8, k, r, i);
    check_val("R4 oversize head irq", longint'(i), 0);
    read_ptr(1'b1, 2, v);
    check_val("R4 head kept", v, 2);

    // R2: two slots of index 2 reach different queues
    ring(slot(2, SQ_SLOT), 7, k, r, i);
    check_val("R2 sq slot kick", longint'(k), 64'h4);
    check_val("R2 sq slot no irq", longint'(i), 0);
    read_ptr(1'b0, 2, v);
    check_val("R2 sq2 tail", v, 7);
    read_ptr(1'b1, 2, v);
    check_val("R2 cq2 head unchanged", v, 2);

    // R8: delete then recreate
    cfg(1'b0, 1'b0, 1, 0, 0);
    ring(slot(1, SQ_SLOT), 1, k, r, i);
    check_val("R8 deleted queue kick", longint'(k), 0);
    read_ptr(1'b0, 1, v);
    check_val("R8 deleted tail kept", v, 2);
    cfg(1'b0, 1'b1, 1, 4, 1);
    read_ptr(1'b0, 1, v);
    check_val("R8 recreate zero tail", v, 0);

    // Mixed traffic against the model (R1 to R9)
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      db_wr_en   = ($urandom_range(0, 3) != 0);
      db_wr_addr = AW'(BASE - 16 + $urandom_range(0, 8 * NQ + 48));
      if ($urandom_range(0, 3) == 0)
        db_wr_addr = AW'(BASE + 8 * $urandom_range(0, 7) + 4 * $urandom_range(0, 1));
      db_wr_data = DW'({$urandom_range(0, 65535), 16'(0)}) | DW'($urandom_range(0, 18));
      cq_tail_en  = ($urandom_range(0, 2) == 0);
      cq_tail_qid = QW'($urandom_range(0, 7));
      cq_tail_val = PW'($urandom_range(0, 17));
      q_cfg_en    = ($urandom_range(0, 15) == 0);
      q_cfg_is_cq = $urandom_range(0, 1);
      q_cfg_create = ($urandom_range(0, 3) != 0);
      q_cfg_qid   = QW'($urandom_range(0, 7));
      q_cfg_size  = PW'($urandom_range(1, 16));
      q_cfg_cq_bind = QW'($urandom_range(0, 7));
      rd_is_cq    = $urandom_range(0, 1);
      rd_qid      = QW'($urandom_range(0, 7));
    end
    @(negedge clk);
    db_wr_en = 1'b0; cq_tail_en = 1'b0; q_cfg_en = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule